// File: doc/BRIEF.md
# Power-of-Two Region Alignment Checker

This block decides whether a proposed memory region can be expressed by a single base/mask range register. The region arrives as a page-numbered base, a page count and a memory type. A start pulse loads the request, and the block computes the last page of the region. It then shifts the base and the last page right together, one bit per cycle, while the base ends in a zero bit and the last page ends in a one bit. The region is acceptable only when the two shifted values are equal at the point the loop stops.

An optional erratum filter can be switched on for each request. With the filter on, the block rejects a base that does not fall on a 1024-page boundary. It also rejects a write-back or write-combining region that overlaps a small forbidden page window. These checks, and the rejection of an empty region, give their verdict one cycle after start. Every verdict is reported with a pass flag, a two-bit reason code and a one-cycle done pulse.

Top module: `region_align_chk`

## Requirements
- R1: During and after reset, with no request made, busy_o, done_o, pass_o are 0 and reason_o is 0.
- R2: The last page is base_i + size_i - 1, computed with one extra bit so that it cannot wrap. A region whose base is a multiple of its power-of-two size passes with pass_o=1 and reason_o=0 (ok).
- R3: A region that is not naturally aligned, or whose size is not a power of two, fails with pass_o=0 and reason_o=1 (misaligned).
- R4: A size_i of 0 fails with reason_o=1, and done_o rises in the cycle after start, ahead of any erratum check.
- R5: With erratum_i=1, a base whose low 10 bits are not all zero fails with reason_o=2. This check takes precedence over the window check and over the shift loop.
- R6: With erratum_i=1, a region of type_i 1 (write-combining) or type_i 6 (write-back) whose pages overlap 0x70000..0x7003F fails with reason_o=3. Regions of any other type, or regions that do not overlap the window, are not affected by this check.
- R7: With erratum_i=0, neither the base alignment rule nor the window rule has any effect on the verdict.
- R8: done_o is high for exactly one cycle per accepted request. It rises no more than PW+2 cycles after the start cycle.
- R9: A start_i pulse that arrives while busy_o is high is ignored. It produces no done pulse and does not change the pending verdict.
- R10: pass_o and reason_o hold their value between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, accepted while idle |
| base_i | input | PW | First page of the region |
| size_i | input | PW | Region length in pages |
| type_i | input | 3 | Memory type (1 write-combining, 6 write-back) |
| erratum_i | input | 1 | Enables the erratum alignment and window rules |
| busy_o | output | 1 | Shift loop in progress |
| done_o | output | 1 | One-cycle verdict strobe |
| pass_o | output | 1 | Verdict: region acceptable |
| reason_o | output | 2 | 0 ok, 1 misaligned, 2 erratum alignment, 3 forbidden window |

## Verification
The assertions assume that request inputs matter only in the cycle that start_i is high. They also assume that a start_i pulse while busy_o is high is ignored rather than queued, so a verdict always pairs with the request that started the loop. The bench drives start_i for a single cycle from idle. It waits for done_o before issuing the next vector, except in the one directed test that deliberately strobes start_i during a long loop. Because the loop-length bound is checked with a cycle counter in the checker, the bench includes a base and size pair that forces the longest shift run.

// File: rtl/region_align_pkg.sv
package region_align_pkg;
  typedef enum logic [1:0] {
    RSN_OK        = 2'd0,
    RSN_MISALIGN  = 2'd1,
    RSN_ERR_ALIGN = 2'd2,
    RSN_WINDOW    = 2'd3
  } reason_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } state_e;
endpackage

// File: rtl/region_precheck.sv
module region_precheck
  import region_align_pkg::*;
#(
  parameter int unsigned PW        = 24,
  parameter int unsigned TW        = 3,
  parameter int unsigned ALIGN_LOG = 10,
  parameter logic [PW-1:0] WIN_LO  = PW'(24'h070000),
  parameter logic [PW-1:0] WIN_HI  = PW'(24'h07003F),
  parameter logic [TW-1:0] TYPE_WC = TW'(1),
  parameter logic [TW-1:0] TYPE_WB = TW'(6)
) (
  input  logic [PW-1:0] base_i,
  input  logic [PW:0]   last_i,
  input  logic [PW-1:0] size_i,
  input  logic [TW-1:0] type_i,
  input  logic          erratum_i,
  output logic          fail_o,
  output reason_e       reason_o
);
  logic size_zero, align_bad, win_hit, risky_type;

  assign size_zero  = (size_i == '0);
  assign align_bad  = (base_i[ALIGN_LOG-1:0] != '0);
  assign risky_type = (type_i == TYPE_WC) || (type_i == TYPE_WB);
  // overlap test valid only for non-empty regions
  assign win_hit    = (last_i >= {1'b0, WIN_LO}) && (base_i <= WIN_HI);

  always_comb begin
    fail_o   = 1'b1;
    reason_o = RSN_OK;
    if (size_zero)                                reason_o = RSN_MISALIGN;
    else if (erratum_i && align_bad)              reason_o = RSN_ERR_ALIGN;
    else if (erratum_i && risky_type && win_hit)  reason_o = RSN_WINDOW;
    else                                          fail_o   = 1'b0;
  end
endmodule

// File: rtl/region_shift_unit.sv
module region_shift_unit #(
  parameter int unsigned PW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [PW-1:0] base_i,
  input  logic [PW:0]   last_i,
  output logic          more_o,
  output logic          equal_o
);
  logic [PW:0] b_q, l_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_q <= '0;
      l_q <= '0;
    end else if (load_i) begin
      b_q <= {1'b0, base_i};
      l_q <= last_i;
    end else if (step_i) begin
      b_q <= b_q >> 1;
      l_q <= l_q >> 1;
    end
  end

  assign more_o  = !b_q[0] && l_q[0];
  assign equal_o = (b_q == l_q);
endmodule

// File: rtl/region_align_chk.sv
module region_align_chk
  import region_align_pkg::*;
#(
  parameter int unsigned PW        = 24,
  parameter int unsigned TW        = 3,
  parameter int unsigned ALIGN_LOG = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [PW-1:0] base_i,
  input  logic [PW-1:0] size_i,
  input  logic [TW-1:0] type_i,
  input  logic          erratum_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic [1:0]    reason_o
);
  state_e  state_q;
  logic    done_q, pass_q;
  reason_e reason_q;
  logic [PW:0] last_w;
  logic    pre_fail;
  reason_e pre_reason;
  logic    accept, load, step, more, equal;

  assign last_w = {1'b0, base_i} + {1'b0, size_i} - (PW+1)'(1);

  region_precheck #(.PW(PW), .TW(TW), .ALIGN_LOG(ALIGN_LOG)) u_pre (
    .base_i    (base_i),
    .last_i    (last_w),
    .size_i    (size_i),
    .type_i    (type_i),
    .erratum_i (erratum_i),
    .fail_o    (pre_fail),
    .reason_o  (pre_reason)
  );

  assign accept = start_i && (state_q == ST_IDLE);
  assign load   = accept && !pre_fail;
  assign step   = (state_q == ST_RUN) && more;

  region_shift_unit #(.PW(PW)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .base_i  (base_i),
    .last_i  (last_w),
    .more_o  (more),
    .equal_o (equal)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      done_q   <= 1'b0;
      pass_q   <= 1'b0;
      reason_q <= RSN_OK;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (pre_fail) begin
            done_q   <= 1'b1;
            pass_q   <= 1'b0;
            reason_q <= pre_reason;
          end else begin
            state_q  <= ST_RUN;
          end
        end
        ST_RUN: if (!more) begin
          state_q  <= ST_IDLE;
          done_q   <= 1'b1;
          pass_q   <= equal;
          reason_q <= equal ? RSN_OK : RSN_MISALIGN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q == ST_RUN);
  assign done_o   = done_q;
  assign pass_o   = pass_q;
  assign reason_o = reason_q;
endmodule

// File: rtl/region_align_chk_sva.sv
module region_align_chk_sva #(
  parameter int unsigned PW = 24
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       pass_o,
  input logic [1:0] reason_o
);
  logic [7:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 8'd1;
    else             run_cnt <= '0;
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_RUN_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt <= 8'(PW + 2)); // R8

  AST_PASS_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && pass_o |-> reason_o == 2'd0); // R2

  AST_FAIL_CODED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !pass_o |-> reason_o != 2'd0); // R3

  AST_HOLD_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(pass_o) && $stable(reason_o)); // R10

  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> busy_o || done_o); // R9

  AST_IDLE_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> !done_o); // R8
endmodule

bind region_align_chk region_align_chk_sva #(.PW(PW)) u_sva (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .pass_o   (pass_o),
  .reason_o (reason_o)
);

// File: tb/tb_region_align_chk.sv
module tb_region_align_chk;
  localparam int PW = 24;
  localparam int NV = 20;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [PW-1:0] base_i = '0;
  logic [PW-1:0] size_i = '0;
  logic [2:0]    type_i = '0;
  logic          erratum_i = 1'b0;
  logic          busy_o, done_o, pass_o;
  logic [1:0]    reason_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  region_align_chk dut (.*);

  // {base, size, type, erratum, exp_pass, exp_reason}
  localparam logic [54:0] VEC [NV] = '{
    {24'h000000, 24'h000001, 3'd0, 1'b0, 1'b1, 2'd0},
    {24'h000100, 24'h000100, 3'd0, 1'b0, 1'b1, 2'd0},
    {24'h000100, 24'h000180, 3'd0, 1'b0, 1'b0, 2'd1},
    {24'h000080, 24'h000100, 3'd0, 1'b0, 1'b0, 2'd1},
    {24'h800000, 24'h800000, 3'd6, 1'b0, 1'b1, 2'd0},
    {24'h000000, 24'hFFFFFF, 3'd0, 1'b0, 1'b0, 2'd1},
    {24'h000400, 24'h000000, 3'd0, 1'b0, 1'b0, 2'd1},
    {24'h000400, 24'h000400, 3'd0, 1'b1, 1'b1, 2'd0},
    {24'h000200, 24'h000200, 3'd0, 1'b1, 1'b0, 2'd2},
    {24'h070000, 24'h000400, 3'd6, 1'b1, 1'b0, 2'd3},
    {24'h070000, 24'h000400, 3'd0, 1'b1, 1'b1, 2'd0},
    {24'h070000, 24'h000400, 3'd1, 1'b1, 1'b0, 2'd3},
    {24'h070000, 24'h000400, 3'd6, 1'b0, 1'b1, 2'd0},
    {24'h06FC00, 24'h000400, 3'd6, 1'b1, 1'b1, 2'd0},
    {24'h06FC00, 24'h000401, 3'd6, 1'b1, 1'b0, 2'd3},
    {24'h070400, 24'h000400, 3'd1, 1'b1, 1'b1, 2'd0},
    {24'h000200, 24'h000200, 3'd0, 1'b0, 1'b1, 2'd0},
    {24'h000200, 24'h000000, 3'd6, 1'b1, 1'b0, 2'd1},
    {24'hFFFFFF, 24'h000002, 3'd0, 1'b0, 1'b0, 2'd1},
    {24'h000003, 24'h000001, 3'd0, 1'b0, 1'b1, 2'd0}
  };
  localparam string TAG [NV] = '{
    "R2", "R2", "R3", "R3", "R2", "R3", "R4", "R5", "R5", "R6",
    "R6", "R6", "R7", "R6", "R6", "R6", "R7", "R4", "R3", "R2"
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // returns number of cycles from start to done, -1 on timeout
  task automatic run_req(input logic [23:0] b, input logic [23:0] s,
                         input logic [2:0] t, input logic e, output int lat);
    @(negedge clk_i);
    base_i = b; size_i = s; type_i = t; erratum_i = e; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 60) begin
      @(negedge clk_i);
      lat++;
    end
    if (!done_o) lat = -1;
  endtask

  initial begin
    int lat;
    int pulses;
    repeat (3) @(negedge clk_i);
    check("R1", int'(busy_o), 0);
    check("R1", int'(done_o), 0);
    check("R1", int'(pass_o), 0);
    check("R1", int'(reason_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1", int'({busy_o, done_o, pass_o, reason_o}), 0);

    for (int i = 0; i < NV; i++) begin
      run_req(VEC[i][54:31], VEC[i][30:7], VEC[i][6:4], VEC[i][3], lat);
      check(TAG[i], int'(pass_o), int'(VEC[i][2]));
      check(TAG[i], int'(reason_o), int'(VEC[i][1:0]));
      check("R8", int'(lat > 0 && lat <= PW + 2), 1);
      @(negedge clk_i);
      check("R8", int'(done_o), 0);
    end

    // R4: empty region answers in the cycle after start
    run_req(24'h000010, 24'h0, 3'd0, 1'b0, lat);
    check("R4", lat, 1);

    // R8: longest loop, base 0 with last page all ones
    run_req(24'h000000, 24'h800000, 3'd0, 1'b0, lat);
    check("R8", int'(pass_o), 1);
    check("R8", int'(lat <= PW + 2 && lat >= PW), 1);

    // R10: verdict held while idle
    repeat (5) @(negedge clk_i);
    check("R10", int'(pass_o), 1);
    check("R10", int'(reason_o), 0);

    // R9: start during a long loop is ignored
    @(negedge clk_i);
    base_i = 24'h800000; size_i = 24'h800000; type_i = 3'd0; erratum_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R9", int'(busy_o), 1);
    base_i = 24'h000001; size_i = 24'h0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    pulses = 0;
    for (int c = 0; c < 40; c++) begin
      if (done_o) begin
        pulses++;
        check("R9", int'(pass_o), 1);
        check("R9", int'(reason_o), 0);
      end
      @(negedge clk_i);
    end
    check("R9", pulses, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule